// File: doc/BRIEF.md
# Register Write-Protect Gate

This block decides whether a command that writes the status or configuration registers of a serial memory is carried out or dropped without a trace. It keeps the four protected register images itself (status and configuration, each with a non-volatile and a volatile copy). For each incoming command it compares three things: the level of the active-low write-protect pin, the write-disable bit of the non-volatile status image and the quad-mode bit of the volatile configuration image. An accepted command updates the images. It also drives a one-cycle write-enable mask, so that registers held elsewhere in the chip can follow.

Two command kinds reach the block. The paired write loads status and configuration together. The single write loads one register that the selector names. Protection is active only when all three conditions hold: the pin is low, the write-disable bit is set and quad mode is off. With quad mode on, the pin acts as a data line and plays no part in the decision. A rejected command sets no flag and changes no image. An accepted write raises the busy bit of the volatile status image for a fixed number of cycles, and the block ignores further commands until that bit clears. The pad pull-up makes a floating pin read high, which leaves the registers unprotected.

Top module: `regwr_guard`

## Requirements
- R1: After reset all four images are 0x00, the busy bit (bit 1 of the volatile status image) is 0 and `wr_en_o` is all zero.
- R2: An accepted paired write (`cmd_op_i` = 1) drives `wr_en_o` = 0x0F for one cycle after the strobe edge. The same edge loads `cmd_data_i[7:0]` into both status images and `cmd_data_i[15:8]` into both configuration images.
- R3: An accepted single write (`cmd_op_i` = 2) drives `wr_en_o` one-hot at bit `cmd_sel_i` and loads `cmd_data_i[7:0]` into the selected image. The selector codes are 0 = status non-volatile, 1 = status volatile, 2 = config non-volatile and 3 = config volatile; codes 4 to 7 name registers held outside the block.
- R4: Protection holds when `wp_ni` = 0, bit 7 of the non-volatile status image is 1 and bit 1 of the volatile config image is 0. While it holds, a paired write or a single write with selector 0 to 3 gives `wr_en_o` = 0, changes no image bit and leaves busy at 0. No error indication of any kind appears.
- R5: A pin held high never blocks a write, whatever the write-disable bit is.
- R6: While bit 1 of the volatile config image is 1, the pin has no effect and writes that are otherwise valid are accepted.
- R7: A single write with selector 4 to 7 is accepted whatever the pin, the write-disable bit or the quad bit.
- R8: After an accepted write, bit 1 of the volatile status image reads 1 for exactly `BUSY_CYCLES` cycles and then 0. Data written to that bit is discarded.
- R9: A command that arrives while busy is 1 is ignored: no enable is raised and no image changes.
- R10: Opcodes 0 and 3, and any cycle with `cmd_valid_i` low, cause no write.
- R11: `wr_data_o` carries the accepted command's 16-bit data in the same cycle as the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe, one cycle |
| cmd_op_i | input | 2 | 0 none, 1 paired write, 2 single write, 3 reserved |
| cmd_sel_i | input | 3 | Target register of a single write |
| cmd_data_i | input | 16 | Low byte status/single data, high byte config data |
| wp_ni | input | 1 | Write-protect pin level, low protects |
| wr_en_o | output | 8 | One-cycle write-enable mask, one bit per selector |
| wr_data_o | output | 16 | Data of the last accepted command |
| stat_nv_o | output | 8 | Non-volatile status image, bit 7 write-disable |
| stat_v_o | output | 8 | Volatile status image, bit 1 busy |
| cfg_nv_o | output | 8 | Non-volatile config image |
| cfg_v_o | output | 8 | Volatile config image, bit 1 quad mode |

## Verification
The properties assume that the command inputs and the pin hold a known, settled level at each rising edge, and that a strobe lasts one cycle. The bench drives every input on the falling edge and raises the strobe for exactly one cycle. It covers the full cross of pin level, write-disable bit, quad bit and the nine targets. Before each target command it sets the write-disable and quad bits with the pin held high, so the state under test is always reached by legal, unprotected writes.

// File: rtl/rwg_pkg.sv
package rwg_pkg;
  typedef enum logic [1:0] {
    OP_IDLE    = 2'd0,
    OP_WR_PAIR = 2'd1,
    OP_WR_ONE  = 2'd2,
    OP_RSVD    = 2'd3
  } op_e;

  // selector codes of the guarded group; codes at or above NUM_GUARDED are external
  localparam int unsigned SEL_STAT_NV = 0;
  localparam int unsigned SEL_STAT_V  = 1;
  localparam int unsigned SEL_CFG_NV  = 2;
  localparam int unsigned SEL_CFG_V   = 3;
  localparam int unsigned NUM_GUARDED = 4;

  localparam int unsigned WD_BIT   = 7;  // non-volatile status
  localparam int unsigned QUAD_BIT = 1;  // volatile config
  localparam int unsigned BUSY_BIT = 1;  // volatile status
endpackage

// File: rtl/rwg_gate.sv
module rwg_gate
  import rwg_pkg::*;
#(
  parameter int unsigned NUM_SEL = 8,
  parameter int unsigned SEL_W   = $clog2(NUM_SEL)
) (
  input  logic               valid_i,
  input  logic [1:0]         op_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic               wp_ni,
  input  logic               wd_i,
  input  logic               quad_i,
  input  logic               busy_i,
  output logic               accept_o,
  output logic               pair_o,
  output logic [NUM_SEL-1:0] mask_o
);
  op_e  op;
  logic is_pair, is_one, guard_on, hits_guarded;

  assign op       = op_e'(op_i);
  assign is_pair  = (op == OP_WR_PAIR);
  assign is_one   = (op == OP_WR_ONE);
  // pin only counts with quad mode off
  assign guard_on = !quad_i && !wp_ni && wd_i;
  assign hits_guarded = is_pair || (is_one && (sel_i < SEL_W'(NUM_GUARDED)));

  assign accept_o = valid_i && !busy_i && (is_pair || is_one) && !(guard_on && hits_guarded);
  assign pair_o   = is_pair;

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_mask
    localparam logic IN_GROUP = (g < NUM_GUARDED);
    assign mask_o[g] = is_pair ? IN_GROUP : (sel_i == SEL_W'(g));
  end
endmodule

// File: rtl/rwg_busy.sv
module rwg_busy #(
  parameter int unsigned BUSY_CYCLES = 4,
  localparam int unsigned CNT_W = $clog2(BUSY_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (start_i) begin
      cnt_q <= CNT_W'(BUSY_CYCLES);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/rwg_regs.sv
module rwg_regs
  import rwg_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned NUM_SEL = 8,
  localparam int unsigned CMD_W  = 2 * DATA_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic               pair_i,
  input  logic [NUM_SEL-1:0] mask_i,
  input  logic [CMD_W-1:0]   data_i,
  output logic [NUM_SEL-1:0] wr_en_o,
  output logic [CMD_W-1:0]   wr_data_o,
  output logic [DATA_W-1:0]  stat_nv_o,
  output logic [DATA_W-1:0]  stat_v_o,
  output logic [DATA_W-1:0]  cfg_nv_o,
  output logic [DATA_W-1:0]  cfg_v_o
);
  localparam logic [DATA_W-1:0] BUSY_MASK = DATA_W'(1) << BUSY_BIT;

  logic [DATA_W-1:0] lo_byte, hi_byte, cfg_src;

  assign lo_byte = data_i[DATA_W-1:0];
  assign hi_byte = data_i[CMD_W-1:DATA_W];
  // paired write carries config in the upper byte
  assign cfg_src = pair_i ? hi_byte : lo_byte;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_o   <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= we_i ? mask_i : '0;
      if (we_i) wr_data_o <= data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_nv_o <= '0;
      stat_v_o  <= '0;
      cfg_nv_o  <= '0;
      cfg_v_o   <= '0;
    end else if (we_i) begin
      if (mask_i[SEL_STAT_NV]) stat_nv_o <= lo_byte;
      if (mask_i[SEL_STAT_V])  stat_v_o  <= lo_byte & ~BUSY_MASK;
      if (mask_i[SEL_CFG_NV])  cfg_nv_o  <= cfg_src;
      if (mask_i[SEL_CFG_V])   cfg_v_o   <= cfg_src;
    end
  end
endmodule

// File: rtl/regwr_guard.sv
module regwr_guard
  import rwg_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned NUM_SEL     = 8,
  parameter int unsigned BUSY_CYCLES = 4,
  localparam int unsigned SEL_W      = $clog2(NUM_SEL),
  localparam int unsigned CMD_W      = 2 * DATA_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_valid_i,
  input  logic [1:0]         cmd_op_i,
  input  logic [SEL_W-1:0]   cmd_sel_i,
  input  logic [CMD_W-1:0]   cmd_data_i,
  input  logic               wp_ni,
  output logic [NUM_SEL-1:0] wr_en_o,
  output logic [CMD_W-1:0]   wr_data_o,
  output logic [DATA_W-1:0]  stat_nv_o,
  output logic [DATA_W-1:0]  stat_v_o,
  output logic [DATA_W-1:0]  cfg_nv_o,
  output logic [DATA_W-1:0]  cfg_v_o
);
  logic               accept, pair, busy;
  logic [NUM_SEL-1:0] mask;
  logic [DATA_W-1:0]  stat_v_raw;

  rwg_gate #(.NUM_SEL(NUM_SEL), .SEL_W(SEL_W)) u_gate (
    .valid_i (cmd_valid_i),
    .op_i    (cmd_op_i),
    .sel_i   (cmd_sel_i),
    .wp_ni   (wp_ni),
    .wd_i    (stat_nv_o[WD_BIT]),
    .quad_i  (cfg_v_o[QUAD_BIT]),
    .busy_i  (busy),
    .accept_o(accept),
    .pair_o  (pair),
    .mask_o  (mask)
  );

  rwg_busy #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(accept),
    .busy_o (busy)
  );

  rwg_regs #(.DATA_W(DATA_W), .NUM_SEL(NUM_SEL)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (accept),
    .pair_i   (pair),
    .mask_i   (mask),
    .data_i   (cmd_data_i),
    .wr_en_o  (wr_en_o),
    .wr_data_o(wr_data_o),
    .stat_nv_o(stat_nv_o),
    .stat_v_o (stat_v_raw),
    .cfg_nv_o (cfg_nv_o),
    .cfg_v_o  (cfg_v_o)
  );

  always_comb begin
    stat_v_o           = stat_v_raw;
    stat_v_o[BUSY_BIT] = busy;
  end
endmodule

// File: rtl/rwg_guard_chk.sv
module rwg_guard_chk
  import rwg_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned NUM_SEL     = 8,
  parameter int unsigned BUSY_CYCLES = 4,
  localparam int unsigned SEL_W      = $clog2(NUM_SEL),
  localparam int unsigned RUN_W      = $clog2(BUSY_CYCLES + 2)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cmd_valid_i,
  input logic [1:0]         cmd_op_i,
  input logic [SEL_W-1:0]   cmd_sel_i,
  input logic               wp_ni,
  input logic [NUM_SEL-1:0] wr_en_o,
  input logic [DATA_W-1:0]  stat_nv_o,
  input logic               busy_i,
  input logic [DATA_W-1:0]  cfg_nv_o,
  input logic [DATA_W-1:0]  cfg_v_o
);
  logic [RUN_W-1:0] run_q;
  logic             guard_on, is_pair, is_one;

  assign guard_on = !wp_ni && stat_nv_o[WD_BIT] && !cfg_v_o[QUAD_BIT];
  assign is_pair  = (cmd_op_i == OP_WR_PAIR);
  assign is_one   = (cmd_op_i == OP_WR_ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= '0;
    else if (busy_i) run_q <= run_q + 1'b1;
    else run_q <= '0;
  end

  // R4
  blocked_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && guard_on && (is_pair || (is_one && cmd_sel_i < SEL_W'(NUM_GUARDED)))
    |=> wr_en_o == '0);

  // R4
  image_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o == '0 |-> $stable(stat_nv_o) && $stable(cfg_nv_o) && $stable(cfg_v_o));

  // R6
  quad_bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && is_pair && cfg_v_o[QUAD_BIT] && !busy_i |=> wr_en_o[SEL_STAT_NV]);

  // R7
  external_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && is_one && cmd_sel_i >= SEL_W'(NUM_GUARDED) && !busy_i
    |=> wr_en_o[$past(cmd_sel_i)]);

  // R8
  busy_on_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o != '0 |-> busy_i);

  // R8
  busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> run_q == RUN_W'(BUSY_CYCLES));

  // R9
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> wr_en_o == '0);

  // R3
  mask_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_en_o) || wr_en_o == NUM_SEL'(4'hF));
endmodule

bind regwr_guard rwg_guard_chk #(
  .DATA_W(DATA_W), .NUM_SEL(NUM_SEL), .BUSY_CYCLES(BUSY_CYCLES)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_valid_i(cmd_valid_i),
  .cmd_op_i   (cmd_op_i),
  .cmd_sel_i  (cmd_sel_i),
  .wp_ni      (wp_ni),
  .wr_en_o    (wr_en_o),
  .stat_nv_o  (stat_nv_o),
  .busy_i     (stat_v_o[rwg_pkg::BUSY_BIT]),
  .cfg_nv_o   (cfg_nv_o),
  .cfg_v_o    (cfg_v_o)
);

// File: tb/regwr_guard_tb.sv
module regwr_guard_tb;
  localparam int unsigned N = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic [1:0]  cmd_op_i = '0;
  logic [2:0]  cmd_sel_i = '0;
  logic [15:0] cmd_data_i = '0;
  logic        wp_ni = 1'b1;
  logic [7:0]  wr_en_o;
  logic [15:0] wr_data_o;
  logic [7:0]  stat_nv_o, stat_v_o, cfg_nv_o, cfg_v_o;

  int checks = 0;
  int fails  = 0;
  logic [7:0] m_snv = '0, m_sv = '0, m_cnv = '0, m_cv = '0;

  always #4 clk = ~clk;

  regwr_guard #(.DATA_W(8), .NUM_SEL(8), .BUSY_CYCLES(N)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i),
    .cmd_sel_i(cmd_sel_i), .cmd_data_i(cmd_data_i), .wp_ni(wp_ni),
    .wr_en_o(wr_en_o), .wr_data_o(wr_data_o), .stat_nv_o(stat_nv_o),
    .stat_v_o(stat_v_o), .cfg_nv_o(cfg_nv_o), .cfg_v_o(cfg_v_o)
  );

  function automatic logic f_guard(input logic wp, input logic [7:0] snv, input logic [7:0] cv);
    return !cv[1] && !wp && snv[7];
  endfunction

  function automatic logic f_accept(input logic [1:0] op, input logic [2:0] sel, input logic wp);
    logic hit;
    hit = (op == 2'd1) || (op == 2'd2 && sel < 3'd4);
    return (op == 2'd1 || op == 2'd2) && !(f_guard(wp, m_snv, m_cv) && hit);
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic check_imgs(input string req);
    check(stat_nv_o == m_snv, req, 32'(stat_nv_o), 32'(m_snv));
    check((stat_v_o & 8'hFD) == m_sv, req, 32'(stat_v_o & 8'hFD), 32'(m_sv));
    check(cfg_nv_o == m_cnv, req, 32'(cfg_nv_o), 32'(m_cnv));
    check(cfg_v_o == m_cv, req, 32'(cfg_v_o), 32'(m_cv));
  endtask

  // called just after a falling edge
  task automatic issue(input logic [1:0] op, input logic [2:0] sel, input logic [15:0] d,
                       input logic wp, input string req);
    logic acc;
    logic [7:0] exp_en;
    acc = f_accept(op, sel, wp);
    cmd_valid_i = 1'b1; cmd_op_i = op; cmd_sel_i = sel; cmd_data_i = d; wp_ni = wp;
    @(negedge clk);
    cmd_valid_i = 1'b0;
    exp_en = '0;
    if (acc) begin
      if (op == 2'd1) begin
        exp_en = 8'h0F;
        m_snv = d[7:0]; m_sv = d[7:0] & 8'hFD; m_cnv = d[15:8]; m_cv = d[15:8];
      end else begin
        exp_en = 8'(1) << sel;
        case (sel)
          3'd0: m_snv = d[7:0];
          3'd1: m_sv  = d[7:0] & 8'hFD;
          3'd2: m_cnv = d[7:0];
          3'd3: m_cv  = d[7:0];
          default: ;
        endcase
      end
    end
    check(wr_en_o == exp_en, req, 32'(wr_en_o), 32'(exp_en));
    if (acc) check(wr_data_o == d, "R11", 32'(wr_data_o), 32'(d));
    check_imgs(req);
    check(stat_v_o[1] == acc, "R8", 32'(stat_v_o[1]), 32'(acc));
    if (acc) begin
      for (int i = 1; i < int'(N); i++) begin
        if (i == 1) begin
          cmd_valid_i = 1'b1; cmd_op_i = 2'd1; cmd_data_i = 16'hA55A; wp_ni = 1'b1;
        end
        @(negedge clk);
        cmd_valid_i = 1'b0;
        if (i == 1) begin
          check(wr_en_o == 8'h00, "R9", 32'(wr_en_o), 32'h0);
          check_imgs("R9");
        end
        check(stat_v_o[1] == 1'b1, "R8", 32'(stat_v_o[1]), 32'h1);
      end
      @(negedge clk);
      check(stat_v_o[1] == 1'b0, "R8", 32'(stat_v_o[1]), 32'h0);
    end
  endtask

  initial begin
    #(8 * 20000);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    string tg;
    logic g;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(stat_nv_o == 8'h00 && cfg_nv_o == 8'h00, "R1", 32'({stat_nv_o, cfg_nv_o}), 32'h0);
    check(stat_v_o == 8'h00 && cfg_v_o == 8'h00, "R1", 32'({stat_v_o, cfg_v_o}), 32'h0);
    check(wr_en_o == 8'h00, "R1", 32'(wr_en_o), 32'h0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R10 strobe low with a paired write on the bus
    cmd_op_i = 2'd1; cmd_data_i = 16'hFFFF; wp_ni = 1'b1;
    @(negedge clk);
    check(wr_en_o == 8'h00, "R10", 32'(wr_en_o), 32'h0);
    check_imgs("R10");
    issue(2'd0, 3'd0, 16'h1234, 1'b1, "R10");
    issue(2'd3, 3'd1, 16'h5678, 1'b0, "R10");
    issue(2'd1, 3'd0, 16'h5A3C, 1'b1, "R2");

    // full cross: pin, write-disable, quad, nine targets (8 = paired)
    for (int wp = 0; wp < 2; wp++)
      for (int wd = 0; wd < 2; wd++)
        for (int q = 0; q < 2; q++)
          for (int t = 0; t < 9; t++) begin
            issue(2'd2, 3'd0, {8'h00, wd[0], 7'($urandom)}, 1'b1, "R5");
            issue(2'd2, 3'd3, {8'h00, 6'($urandom), q[0], 1'b0}, 1'b1, "R3");
            g = f_guard(wp[0], m_snv, m_cv);
            if (t >= 4 && t < 8) tg = "R7";
            else if (g) tg = "R4";
            else if (q == 1 && wp == 0 && wd == 1) tg = "R6";
            else if (wp == 1) tg = "R5";
            else if (t == 8) tg = "R2";
            else tg = "R3";
            if (t == 8) issue(2'd1, 3'($urandom), 16'($urandom), wp[0], tg);
            else issue(2'd2, 3'(t), 16'($urandom), wp[0], tg);
          end

    // constrained random mix
    for (int k = 0; k < 200; k++) begin
      logic [1:0] op;
      op = 2'($urandom);
      issue(op, 3'($urandom), 16'($urandom), 1'($urandom),
            (op == 2'd0 || op == 2'd3) ? "R10" : (op == 2'd1 ? "R2" : "R3"));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule